// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous Memory Port

This block produces the word address that a synchronous SRAM core uses during a burst. When either of two active-low address strobes is sampled low at a rising clock edge, it captures the full external address. The upper bits are held for the rest of the burst, and the two lowest bits become the burst start offset. Each later edge at which the active-low advance input is low moves the offset one step through a four-beat sequence. The two orderings are wrap-around counting, where the start value plus the beat number is taken modulo 4, and interleaved, where the start value is XORed with the beat number. The order is chosen by a mode input, with low meaning linear and high meaning interleaved. The high level is the default, so a pulled-up mode pin gives interleaved order. The mode is captured together with the address.

The controller is a small state machine. `ST_IDLE` is held from reset until the first strobe. `ST_BEAT0` to `ST_BEAT3` give the beat number since the last load. It has four kinds of transition:
- LOAD: a strobe seen in any state goes to `ST_BEAT0`.
- STEP: an advance with no strobe goes from `ST_BEATn` to `ST_BEAT(n+1)`.
- WRAP: an advance in `ST_BEAT3` goes to `ST_BEAT0`.
- HOLD: with no strobe and no advance, the state does not change. An advance in `ST_IDLE` is also a HOLD.

Both outputs are registered values, so a strobe or an advance takes effect one cycle after the edge that samples it. A strobe at every edge is allowed, so the burst function can be left unused without any penalty.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `word_addr` and `burst_ofs` are all zeros until the first strobe.
- R2: `strobe_p_n` low at an edge makes `word_addr` equal to the `addr_in` sampled at that edge, from the next cycle on.
- R3: `strobe_c_n` low at an edge loads the address in the same way as R2. Having both strobes low at once counts as a single load.
- R4: After a load, each edge with `adv_n` low and both strobes high moves the burst offset exactly one step.
- R5: If `order_lin_n` was 0 at the load, the offset after n steps is (start + n) mod 4. For example, start 1 gives 1,2,3,0.
- R6: If `order_lin_n` was 1 at the load, the offset after n steps is start XOR (n mod 4). For example, start 1 gives 1,0,3,2.
- R7: During a burst, the bits of `word_addr` above bit 1 stay equal to the loaded address, and bits [1:0] equal `burst_ofs`.
- R8: An edge with both strobes high and `adv_n` high leaves both outputs unchanged.
- R9: A strobe takes priority over an advance at the same edge. The new address appears with no step applied.
- R10: A strobe at every consecutive edge loads each new address in turn, with no idle cycle in between.
- R11: After four steps the offset returns to its start value, and stepping then continues in the same order.
- R12: An advance before the first load after reset is ignored.
- R13: A change of `order_lin_n` during a burst has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | External word address; bits [1:0] are the burst start |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Advance to next burst beat, active low |
| order_lin_n | input | 1 | 0 = linear order, 1 = interleaved order (default) |
| word_addr | output | ADDR_W | Current word address |
| burst_ofs | output | 2 | Current burst offset (equals word_addr[1:0]) |

## Verification
The hardest situations to reach are the ones where several inputs act at the same edge. One is a strobe that arrives together with an advance. Another is a mode change in the middle of a burst. A third is an advance while the sequencer is still idle after reset. The stimulus creates each of these on purpose:
- It holds the advance input low before any address is loaded.
- It flips the mode input between steps of a burst that is already running.
- It drives strobes and advances at the same edges in an uninterrupted run of back-to-back loads.

It also takes every start offset through more than four steps in each order, so that the wrap from the fourth beat back to the first is exercised.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFS_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } burst_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 adv,
    output burst_state_t         state_q,
    output logic [OFS_W-1:0]     beat
);

    burst_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = adv ? ST_BEAT1 : ST_BEAT0;
                ST_BEAT1: state_d = adv ? ST_BEAT2 : ST_BEAT1;
                ST_BEAT2: state_d = adv ? ST_BEAT3 : ST_BEAT2;
                ST_BEAT3: state_d = adv ? ST_BEAT0 : ST_BEAT3;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  beat = 2'd0;
            ST_BEAT0: beat = 2'd0;
            ST_BEAT1: beat = 2'd1;
            ST_BEAT2: beat = 2'd2;
            ST_BEAT3: beat = 2'd3;
            default:  beat = 2'd0;
        endcase
    end

endmodule

// File: rtl/burst_load_reg.sv
module burst_load_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - OFS_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               order_lin_n,
    output logic [UP_W-1:0]    upper_q,
    output logic [OFS_W-1:0]   start_q,
    output burst_order_t       order_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:OFS_W];
            start_q <= addr_in[OFS_W-1:0];
            order_q <= order_lin_n ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] beat,
    input  burst_order_t     order,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    always_comb begin
        lin_ofs = start + beat;
        ilv_ofs = start ^ beat;
        unique case (order)
            ORD_LINEAR:     ofs = lin_ofs;
            ORD_INTERLEAVE: ofs = ilv_ofs;
            default:        ofs = lin_ofs;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] word_addr,
    output logic [1:0]        burst_ofs
);

    localparam int UP_W = ADDR_W - OFS_W;

    logic               load;
    logic               adv;
    burst_state_t       state_q;
    logic [OFS_W-1:0]   beat;
    logic [UP_W-1:0]    upper_q;
    logic [OFS_W-1:0]   start_q;
    burst_order_t       order_q;
    logic [OFS_W-1:0]   ofs;

    assign load = !strobe_p_n || !strobe_c_n;
    assign adv  = !adv_n;

    burst_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .state_q (state_q),
        .beat    (beat)
    );

    burst_load_reg #(.ADDR_W(ADDR_W)) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .addr_in     (addr_in),
        .order_lin_n (order_lin_n),
        .upper_q     (upper_q),
        .start_q     (start_q),
        .order_q     (order_q)
    );

    burst_order_map u_map (
        .start (start_q),
        .beat  (beat),
        .order (order_q),
        .ofs   (ofs)
    );

    always_comb begin
        word_addr = {upper_q, ofs};
        burst_ofs = ofs;
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
)(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_p_n,
    input logic              strobe_c_n,
    input logic              adv_n,
    input logic              order_lin_n,
    input logic [ADDR_W-1:0] word_addr,
    input logic [1:0]        burst_ofs
);

    logic ld;
    logic chk_loaded;
    logic chk_lin;

    assign ld = !strobe_p_n || !strobe_c_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_loaded <= 1'b0;
            chk_lin    <= 1'b0;
        end else if (ld) begin
            chk_loaded <= 1'b1;
            chk_lin    <= !order_lin_n;
        end
    end

    // R2
    load_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_p_n |=> word_addr == $past(addr_in));

    // R3
    load_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_c_n |=> word_addr == $past(addr_in));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_loaded && chk_lin && !adv_n && !ld) |=> burst_ofs == $past(burst_ofs) + 2'd1);

    // R6
    interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_loaded && !chk_lin && !adv_n && !ld) |=> burst_ofs[0] != $past(burst_ofs[0]));

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(word_addr[ADDR_W-1:2]));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |=> $stable(word_addr));

    // R12
    pre_load_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_loaded && !ld) |=> $stable(word_addr));

    // R7
    ofs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> burst_ofs == word_addr[1:0]);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_in     (addr_in),
    .strobe_p_n  (strobe_p_n),
    .strobe_c_n  (strobe_c_n),
    .adv_n       (adv_n),
    .order_lin_n (order_lin_n),
    .word_addr   (word_addr),
    .burst_ofs   (burst_ofs)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strobe_p_n = 1'b1;
    logic              strobe_c_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              order_lin_n = 1'b1;
    logic [ADDR_W-1:0] word_addr;
    logic [1:0]        burst_ofs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int m_upper  = 0;
    int m_start  = 0;
    int m_n      = 0;
    bit m_lin    = 1'b0;
    bit m_loaded = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_in     (addr_in),
        .strobe_p_n  (strobe_p_n),
        .strobe_c_n  (strobe_c_n),
        .adv_n       (adv_n),
        .order_lin_n (order_lin_n),
        .word_addr   (word_addr),
        .burst_ofs   (burst_ofs)
    );

    function automatic int exp_ofs();
        if (m_lin) return (m_start + m_n) % 4;
        return m_start ^ m_n;
    endfunction

    task automatic check(string tag);
        int eo;
        int ea;
        eo = exp_ofs();
        ea = m_upper * 4 + eo;
        n_tests++;
        if (int'(word_addr) != ea || int'(burst_ofs) != eo) begin
            n_fail++;
            $display("FAIL %s: word_addr=%h ofs=%0d expected word_addr=%h ofs=%0d",
                     tag, word_addr, burst_ofs, ea[ADDR_W-1:0], eo);
        end
    endtask

    // apply inputs for one edge, update model at the edge, compare after it
    task automatic cyc(bit p, bit c, bit adv, bit mode, logic [ADDR_W-1:0] a, string tag);
        strobe_p_n  = p;
        strobe_c_n  = c;
        adv_n       = adv;
        order_lin_n = mode;
        addr_in     = a;
        @(posedge clk);
        if (!p || !c) begin
            m_upper  = int'(a) / 4;
            m_start  = int'(a) % 4;
            m_n      = 0;
            m_lin    = (mode == 1'b0);
            m_loaded = 1'b1;
        end else if (!adv && m_loaded) begin
            m_n = (m_n + 1) % 4;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R12: advance before any load
        cyc(1, 1, 0, 1, 18'h3FFFF, "R12 adv idle");
        cyc(1, 1, 0, 0, 18'h12345, "R12 adv idle");

        // R2 + R5: linear from 1, wrap (R11)
        cyc(0, 1, 1, 0, 18'h2A5D1, "R2 load p");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 18'h0, "R5 R11 linear step");
        // R8 hold
        cyc(1, 1, 1, 0, 18'h15555, "R8 hold");
        cyc(1, 1, 1, 1, 18'h0AAAA, "R8 hold");

        // R3 + R6: interleaved from 1
        cyc(1, 0, 1, 1, 18'h1C3A1, "R3 load c");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 1, 18'h0, "R6 R11 interleave step");

        // R13: mode flip mid burst
        cyc(0, 1, 1, 0, 18'h00702, "R2 load linear");
        cyc(1, 1, 0, 1, 18'h0, "R13 mode flip");
        cyc(1, 1, 0, 1, 18'h0, "R13 mode flip");
        cyc(1, 1, 0, 0, 18'h0, "R13 mode back");

        // R9: strobe with advance at the same edge
        cyc(1, 1, 0, 0, 18'h0, "R4 step");
        cyc(0, 1, 0, 1, 18'h04443, "R9 strobe beats adv");
        cyc(1, 0, 0, 0, 18'h38886, "R9 strobe beats adv");
        cyc(0, 0, 0, 1, 18'h2BEEF, "R3 both strobes");

        // every start value, both orders, with R7 checks on upper bits
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a = 18'h10000 + ADDR_W'(s * 4 + 32 * m + s);
                a[1:0] = 2'(s);
                cyc(1, 0, 1, 1'(m), a, "R3 load sweep");
                for (int k = 0; k < 6; k++)
                    cyc(1, 1, 0, 1'(m), 18'h0, m ? "R6 R7 sweep" : "R5 R7 sweep");
            end
        end

        // R10: back-to-back loads
        for (int i = 0; i < 10; i++) begin
            a = ADDR_W'(32'h1357 * (i + 3) + i);
            cyc(1'(i % 2), 1'((i + 1) % 2), 1'(i % 3 == 0), 1'(i % 2), a, "R10 back-to-back");
        end
        cyc(1, 1, 0, 1, 18'h0, "R4 step after run");
        cyc(1, 1, 0, 1, 18'h0, "R4 step after run");

        // R1: reset mid-burst clears state, then advance is ignored again
        rst_n = 1'b0;
        m_upper = 0; m_start = 0; m_n = 0; m_lin = 1'b0; m_loaded = 1'b0;
        @(negedge clk);
        check("R1 reset mid burst");
        rst_n = 1'b1;
        cyc(1, 1, 0, 1, 18'h0, "R12 adv after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule